// File: doc/BRIEF.md
# Serial Configuration Register Target

This block sits on a two-wire serial bus (I2C, standard mode, up to 100 kbit/s) and holds seven 8-bit control registers. A clock-distribution chip uses these registers to turn its output clock pairs on and off. The bus clock and data lines are oversampled by a faster system clock. The block drives the data line only through an open-drain pull-down enable. All seven registers are brought out as one parallel vector, which downstream gating logic uses.

Access is sequential and always starts at register 0. A write sends the address byte, then a command byte and a byte-count byte. The target acknowledges both of these and throws them away. Every byte after them fills registers 0, 1, 2 and so on in turn. A read sends the address byte, and the target answers with a count byte followed by the registers in ascending order. The host may end either kind of access after any whole byte.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges address byte 0xD4 (7-bit address 0x6A, R/W bit 0) as a write and 0xD5 (R/W bit 1) as a read. It acknowledges by pulling SDA low during the ninth clock.
- R2: The target does not acknowledge any other address byte, and it leaves SDA released until the next start condition, even if more bytes follow on the bus.
- R3: In a write, the first two data bytes (command and count) are acknowledged and discarded. Each later byte is acknowledged and stored in register 0, then 1, and upward.
- R4: A stop after any complete byte ends the write. Registers that were written keep their new values, and all other registers keep their previous values.
- R5: In a read, the target sends 0x07 first, then registers 0 to 6 in order. Any byte read after register 6 is 0xFF. A host NACK ends the transfer.
- R6: After reset, registers 0 to 5 read 0xFF and register 6 reads 0x1F.
- R7: Bytes written after register 6 are acknowledged and dropped. Bits 7:5 of register 6 ignore writes and always read 0.
- R8: Bytes on the bus are sent MSB first. The target changes its SDA drive only while SCL is low, except when it lets go of SDA at a start or stop condition.
- R9: A start condition at any point, including in the middle of a byte, restarts address reception. A stop condition at any point returns the target to idle.
- R10: regs_out[8k+7:8k] holds register k. Bits 7:2 of register 5 enable clock pairs 0, 1, 2, 3, 4 and 9. Bits 4:1 of register 6 enable pairs 8, 7, 6 and 5. A 1 enables a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| regs_out | output | 56 | All seven registers; register k is in bits 8k+7:8k |

## Verification
Four properties are checked on every cycle:
- the bits of register 6 that ignore writes stay at zero;
- the SDA drive changes only while SCL is low, outside start and stop handling;
- SDA is released right after a start;
- a foreign address is never acknowledged.

The register contents are also checked to stay stable while a read is in progress.

Some behaviour can only be shown by the bench's transactions:
- the order in which bytes land in the registers;
- the discarded command and count bytes;
- the count byte and the 0xFF padding on reads;
- partial writes;
- restarts in the middle of a byte.

The bench compares each of these against a model of the register file.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int NUM_REGS = 7,
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter logic [7:0] COUNT_BYTE = 8'd7,
  parameter logic [NUM_REGS*8-1:0] RST_VEC = {8'h1F, {(NUM_REGS-1){8'hFF}}},
  parameter logic [NUM_REGS*8-1:0] WR_MASK = {8'h1F, {(NUM_REGS-1){8'hFF}}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_out
);

  localparam int IW = $clog2(NUM_REGS + 3);
  localparam logic [IW-1:0] WCNT_MAX = IW'(NUM_REGS + 2);
  localparam logic [IW-1:0] RCNT_MAX = IW'(NUM_REGS + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_RD, ST_RACK} st_t;

  st_t                  st;
  logic [2:0]           scl_q, sda_q;
  logic [2:0]           bitcnt;
  logic [7:0]           shreg, tx, next_byte;
  logic                 got, rd;
  logic [IW-1:0]        wcnt, rcnt, widx;
  logic [NUM_REGS*8-1:0] regs;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  assign widx     = wcnt - IW'(2);
  assign sda_oe   = (st == ST_ACK) | ((st == ST_RD) & ~tx[7]);
  assign regs_out = regs;

  always_comb begin
    if (rcnt == '0)
      next_byte = COUNT_BYTE;
    else if (int'(rcnt) <= NUM_REGS)
      next_byte = regs[(int'(rcnt) - 1)*8 +: 8];
    else
      next_byte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= 8'hFF;
      got    <= 1'b0;
      rd     <= 1'b0;
      wcnt   <= '0;
      rcnt   <= '0;
      regs   <= RST_VEC;
    end else if (start_c) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      got    <= 1'b0;
      wcnt   <= '0;
      rcnt   <= '0;
    end else if (stop_c) begin
      st  <= ST_IDLE;
      got <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q[1]};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) got <= 1'b1;
          end else if (scl_fall && got) begin
            got    <= 1'b0;
            bitcnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                st <= ST_ACK;
                rd <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st <= ST_ACK;
              if (wcnt >= IW'(2) && wcnt < WCNT_MAX)
                regs[int'(widx)*8 +: 8] <= (shreg & WR_MASK[int'(widx)*8 +: 8]) |
                                           (regs[int'(widx)*8 +: 8] & ~WR_MASK[int'(widx)*8 +: 8]);
              if (wcnt != WCNT_MAX) wcnt <= wcnt + IW'(1);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd) begin
              st <= ST_RD;
              tx <= next_byte;
              if (rcnt != RCNT_MAX) rcnt <= rcnt + IW'(1);
            end else begin
              st <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) st <= ST_RACK;
            else tx <= {tx[6:0], 1'b0};
            bitcnt <= bitcnt + 3'd1;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_q[1]) st <= ST_IDLE;
            else got <= 1'b1;
          end else if (scl_fall && got) begin
            got    <= 1'b0;
            st     <= ST_RD;
            tx     <= next_byte;
            bitcnt <= '0;
            if (rcnt != RCNT_MAX) rcnt <= rcnt + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((regs ^ RST_VEC) & ~WR_MASK) == '0); // R7

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_q[1] || $past(start_c || stop_c))); // R8

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe); // R9

  AST_NO_FOREIGN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && scl_fall && got && shreg[7:1] != DEV_ADDR && !start_c && !stop_c) |=> !sda_oe); // R2

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RD || st == ST_RACK) && !start_c) |=> $stable(regs)); // R5

endmodule

// File: tb/cfg_i2c_target_bench.sv
`timescale 1ns/1ps
module cfg_i2c_target_bench;
  localparam int Q = 8;

  logic        clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic        sda_oe;
  logic [55:0] regs_out;
  logic        line;
  int          total = 0, bad = 0, oe_viol = 0;
  bit          finished = 1'b0;
  logic        prev_oe = 1'b0;
  logic [7:0]  model [7];
  logic [7:0]  dbuf [16];

  assign line = sda_h & ~sda_oe;
  always #2.5 clk = ~clk;

  cfg_i2c_target u_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line),
    .sda_oe(sda_oe), .regs_out(regs_out));

  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [55:0] model_vec();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input int k);
    if (k == 0) return 8'h07;
    if (k <= 7) return model[k-1];
    return 8'hFF;
  endfunction

  function automatic void model_write(input int n);
    for (int i = 2; i < n; i++) begin
      int idx = i - 2;
      logic [7:0] m;
      if (idx < 7) begin
        m = (idx == 6) ? 8'h1F : 8'hFF;
        model[idx] = (dbuf[i] & m) | (model[idx] & ~m);
      end
    end
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_h = b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    send_bits(b, 8);
    sda_h = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    ack_n = line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = line; tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_h = ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    sda_h = 1'b1;
  endtask

  task automatic wr_body(input int n, output int nacks);
    logic a;
    nacks = 0;
    send_byte(8'hD4, a); if (a) nacks++;
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], a); if (a) nacks++;
    end
  endtask

  task automatic wr_txn(input int n, input string tag);
    int nk;
    bus_start();
    wr_body(n, nk);
    bus_stop();
    model_write(n);
    chk({tag, " R1 R3 write acks"}, 64'(nk), 64'd0);
    chk({tag, " R10 register vector"}, 64'(regs_out), 64'(model_vec()));
  endtask

  task automatic rd_body(input int n);
    logic a;
    logic [7:0] b;
    send_byte(8'hD5, a);
    chk("R1 read address ack", 64'(a), 64'd0);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk($sformatf("R5 R8 read byte %0d", k), 64'(b), 64'(exp_read(k)));
    end
  endtask

  task automatic rd_txn(input int n);
    bus_start();
    rd_body(n);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog all R actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic a;
    int   nk;
    int   seed;
    for (int k = 0; k < 6; k++) model[k] = 8'hFF;
    model[6] = 8'h1F;
    tick(5); rst_n = 1'b1; tick(5);

    chk("R6 reset value", 64'(regs_out), 64'h1F_FFFF_FFFF_FFFF);
    rd_txn(10);

    dbuf[0] = 8'hAA; dbuf[1] = 8'h07;
    for (int i = 2; i < 9; i++) dbuf[i] = 8'h00;
    dbuf[9] = 8'h5A; dbuf[10] = 8'hA5;
    wr_txn(11, "clear all");
    chk("R7 reg6 cleared", 64'(regs_out[55:48]), 64'h00);

    for (int i = 2; i < 11; i++) dbuf[i] = 8'hFF;
    wr_txn(11, "set all");
    chk("R7 read-only bits", 64'(regs_out[55:48]), 64'h1F);
    chk("R10 reg5 pair enables", 64'(regs_out[47:42]), 64'h3F);

    dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h3C; dbuf[3] = 8'hC3;
    wr_txn(4, "R4 partial");
    chk("R4 untouched reg2", 64'(regs_out[23:16]), 64'hFF);

    dbuf[0] = 8'h00; dbuf[1] = 8'h00;
    wr_txn(2, "R3 only discarded bytes");
    chk("R3 cmd and count ignored", 64'(regs_out[15:0]), 64'hC33C);

    bus_start();
    send_byte(8'hA0, a);
    chk("R2 foreign address nack", 64'(a), 64'd1);
    send_byte(8'h00, a);
    chk("R2 released after foreign", 64'(a), 64'd1);
    bus_stop();
    bus_start();
    send_byte(8'hD6, a);
    chk("R2 neighbour address nack", 64'(a), 64'd1);
    bus_stop();
    chk("R2 regs untouched", 64'(regs_out), 64'(model_vec()));

    bus_start();
    dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h77;
    wr_body(3, nk);
    model_write(3);
    chk("R9 acks before restart", 64'(nk), 64'd0);
    bus_start();
    rd_body(3);
    bus_stop();

    bus_start();
    send_bits(8'h00, 1);
    bus_stop();
    bus_start();
    send_byte(8'hD4, a);
    bus_stop();
    chk("R9 stop after address", 64'(regs_out), 64'(model_vec()));

    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_bits(8'h00, 3);
    bus_start();
    dbuf[0] = 8'hEE; dbuf[1] = 8'hEE; dbuf[2] = 8'h99;
    wr_body(3, nk);
    bus_stop();
    model_write(3);
    chk("R9 restart mid byte acks", 64'(nk), 64'd0);
    chk("R9 restart mid byte regs", 64'(regs_out), 64'(model_vec()));

    seed = 32'h5EED;
    void'($urandom(seed));
    for (int it = 0; it < 10; it++) begin
      int n = int'($urandom % 12);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      wr_txn(n, "R3 R4 random");
      rd_txn(int'($urandom % 10) + 1);
    end

    chk("R8 sda drive changed with SCL high", 64'(oe_viol), 64'd0);
    summary();
  end
endmodule